// File: doc/BRIEF.md
# Descriptor-Chained Display Frame DMA

This engine drives a display bus from memory with no processor involvement per frame. Software places a ring of descriptors in memory, each eight 32-bit words long, and gives the engine the address of the first one. Setting the enable input starts the engine. It reads the descriptor, acts on it, then follows the descriptor's next pointer. The ring never terminates.

A descriptor is either a command descriptor or a frame descriptor. A command descriptor sends a burst of panel commands. Each memory word is cut into one or more command beats, depending on the build-time command width. A frame descriptor sends pixel words, one per beat, and reports the pixel format it declares.

The first descriptor after a start must be a command. A command with a zero count is legal and is skipped. If software clears enable, the engine finishes the descriptor in progress and then signals that it has stopped. An end-of-frame flag can be requested per frame descriptor and is cleared by a pulse. A misaligned descriptor address halts the engine with an error.

Top module: `dfd_engine`

## Requirements
- R1: After reset, busy, out_valid, mem_req, eof_flag, qd_flag and err_flag are all low.
- R2: A descriptor is read as eight consecutive words starting at a 32-byte-aligned address. If the start address or a next pointer has a nonzero value in bits 4:0, err_flag is set, the engine halts, and no beat is emitted.
- R3: The first descriptor after a start must have bit 29 of word 3 set (command type). Otherwise err_flag is set and no beat is emitted.
- R4: For a command descriptor, word 6 gives the number of beats, and the data comes from the word 1 address onward. With CMD_BITS=8, each word gives four byte beats, least significant byte first, zero-extended. With 9 or 16 it gives two halfword beats, and with 18 or 24 one beat. Each beat is masked to CMD_BITS, and out_is_cmd is 1.
- R5: A command descriptor whose word 6 is zero emits no beat, and the engine proceeds to the next descriptor.
- R6: A frame descriptor with bit 26 of word 3 set emits word 3 bits CNT_W-1:0 memory words, one per beat, with out_is_cmd at 0. If bit 26 is clear, no data is emitted.
- R7: When a frame descriptor is decoded, pix_fmt takes a value from word 6 bits 30:27. The value is 0 for 4'b0100 (16 bpp), 1 for 4'b0101 (18/24 bpp), 2 for 4'b1100 (15 bpp), and 3 otherwise.
- R8: eof_flag is set when the last beat of a frame descriptor with bit 30 of word 3 set is accepted. It stays set until an eof_clr pulse. A frame descriptor without bit 30 leaves it unchanged.
- R9: After each descriptor, the engine continues at the address in word 0, endlessly, while enable stays high.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R11: When enable is low at the end of a descriptor, the engine goes idle and sets qd_flag. Beats of the descriptor in progress are still emitted. qd_flag is cleared by the next start.
- R12: busy is high from the start until the engine goes idle or halts with an error, including while the last beat waits for acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; a high level in idle starts the engine |
| start_addr | input | 32 | Byte address of the first descriptor |
| eof_clr | input | 1 | Pulse that clears eof_flag |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read accepted; mem_rdata valid this cycle |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Beat available on out_data |
| out_ready | input | 1 | Display bus accepts the beat |
| out_data | output | 32 | Beat data |
| out_is_cmd | output | 1 | Beat belongs to a command descriptor |
| busy | output | 1 | Engine active |
| eof_flag | output | 1 | End-of-frame status |
| qd_flag | output | 1 | Engine stopped after enable was cleared |
| err_flag | output | 1 | Misaligned descriptor or bad first descriptor |
| pix_fmt | output | 2 | Pixel format of the latest frame descriptor |

## Verification
The bench builds the engine with CMD_BITS=8 and CNT_W=16. The byte-width variant is the deepest slicing case: it splits one word into four command beats, so a count of five exercises a partial last word. The same ring is then walked into its second lap, which checks that byte ordering restarts cleanly on each command word. A 64-word memory model with immediate acknowledge holds the ring. Back-pressure pauses on both command and frame beats test the hold behaviour.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_CHECK, S_RD, S_OUT, S_NEXT, S_ERR
   } dfd_state_e;

   // descriptor word positions (the chain layout depends on these)
   localparam int unsigned WI_NEXT = 0;
   localparam int unsigned WI_SRC  = 1;
   localparam int unsigned WI_CMD  = 3;
   localparam int unsigned WI_CNT  = 6;
   localparam int unsigned DESC_WORDS = 8;

   // control bits inside the command word
   localparam int unsigned CB_EOF = 30;
   localparam int unsigned CB_CMD = 29;
   localparam int unsigned CB_FRM = 26;

   function automatic int unsigned beats_per_word(input int unsigned bits);
      if (bits <= 8)       return 4;
      else if (bits <= 16) return 2;
      else                 return 1;
   endfunction
endpackage

// File: rtl/dfd_desc_regs.sv
module dfd_desc_regs
   import dfd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [2:0]  idx,
   input  logic [31:0] wdata,
   output logic [31:0] next_addr,
   output logic [31:0] src_addr,
   output logic [31:0] cmd_word,
   output logic [31:0] cnt_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_addr <= '0;
         src_addr  <= '0;
         cmd_word  <= '0;
         cnt_word  <= '0;
      end else if (we) begin
         case (idx)
            3'(WI_NEXT): next_addr <= wdata;
            3'(WI_SRC):  src_addr  <= wdata;
            3'(WI_CMD):  cmd_word  <= wdata;
            3'(WI_CNT):  cnt_word  <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dfd_beat_slice.sv
module dfd_beat_slice
   import dfd_pkg::*;
#(
   parameter int unsigned CMD_BITS = 8
) (
   input  logic [31:0] word,
   input  logic [1:0]  sub,
   input  logic        is_cmd,
   output logic [31:0] beat
);
   localparam int unsigned BPW  = beats_per_word(CMD_BITS);
   localparam int unsigned STEP = 32 / BPW;
   localparam logic [31:0] MASK = 32'((64'd1 << CMD_BITS) - 64'd1);

   logic [31:0] shifted;

   generate
      if (!(CMD_BITS == 8 || CMD_BITS == 9 || CMD_BITS == 16 ||
            CMD_BITS == 18 || CMD_BITS == 24)) begin : g_bad_width
         $error("dfd_beat_slice: CMD_BITS must be 8, 9, 16, 18 or 24");
      end
      if (BPW == 1) begin : g_whole
         assign shifted = word;
      end else begin : g_split
         assign shifted = word >> (32'(sub) * STEP);
      end
   endgenerate

   assign beat = is_cmd ? (shifted & MASK) : word;
endmodule

// File: rtl/dfd_status.sv
module dfd_status (
   input  logic clk,
   input  logic rst_n,
   input  logic eof_set,
   input  logic eof_clr,
   input  logic qd_set,
   input  logic qd_clr,
   input  logic err_set,
   input  logic err_clr,
   output logic eof_flag,
   output logic qd_flag,
   output logic err_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eof_flag <= 1'b0;
         qd_flag  <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         if (eof_set)      eof_flag <= 1'b1;
         else if (eof_clr) eof_flag <= 1'b0;
         if (qd_set)       qd_flag  <= 1'b1;
         else if (qd_clr)  qd_flag  <= 1'b0;
         if (err_set)      err_flag <= 1'b1;
         else if (err_clr) err_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/dfd_engine.sv
module dfd_engine
   import dfd_pkg::*;
#(
   parameter int unsigned CMD_BITS = 8,
   parameter int unsigned CNT_W    = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  logic [31:0] start_addr,
   input  logic        eof_clr,
   output logic        mem_req,
   output logic [31:0] mem_addr,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   output logic        out_valid,
   input  logic        out_ready,
   output logic [31:0] out_data,
   output logic        out_is_cmd,
   output logic        busy,
   output logic        eof_flag,
   output logic        qd_flag,
   output logic        err_flag,
   output logic [1:0]  pix_fmt
);
   localparam int unsigned BPW = beats_per_word(CMD_BITS);
   localparam logic [1:0]  LAST_SUB = 2'(BPW - 1);

   generate
      if (CNT_W < 1 || CNT_W > 26) begin : g_bad_cnt
         $error("dfd_engine: CNT_W must lie in 1..26");
      end
   endgenerate

   dfd_state_e        state;
   logic [2:0]        fidx;
   logic [31:0]       desc_addr, src_ptr, hold;
   logic              first, cur_cmd, cur_eof;
   logic [CNT_W-1:0]  rem;
   logic [1:0]        sub;

   logic [31:0] d_next, d_src, d_cmd, d_cnt;
   logic        fetch_we;
   logic        eof_set, qd_set, qd_clr, err_set, err_clr;

   assign fetch_we = (state == S_FETCH) && mem_ack;

   dfd_desc_regs u_desc (
      .clk(clk), .rst_n(rst_n), .we(fetch_we), .idx(fidx), .wdata(mem_rdata),
      .next_addr(d_next), .src_addr(d_src), .cmd_word(d_cmd), .cnt_word(d_cnt)
   );

   dfd_beat_slice #(.CMD_BITS(CMD_BITS)) u_slice (
      .word(hold), .sub(sub), .is_cmd(cur_cmd), .beat(out_data)
   );

   dfd_status u_status (
      .clk(clk), .rst_n(rst_n),
      .eof_set(eof_set), .eof_clr(eof_clr),
      .qd_set(qd_set), .qd_clr(qd_clr),
      .err_set(err_set), .err_clr(err_clr),
      .eof_flag(eof_flag), .qd_flag(qd_flag), .err_flag(err_flag)
   );

   logic beat_take, last_beat;
   assign out_valid  = (state == S_OUT);
   assign out_is_cmd = cur_cmd;
   assign beat_take  = out_valid && out_ready;
   assign last_beat  = (rem == CNT_W'(1));
   assign busy       = (state != S_IDLE) && (state != S_ERR);

   always_comb begin
      mem_req  = 1'b0;
      mem_addr = '0;
      if (state == S_FETCH) begin
         mem_req  = 1'b1;
         mem_addr = desc_addr + {27'd0, fidx, 2'b00};
      end else if (state == S_RD) begin
         mem_req  = 1'b1;
         mem_addr = src_ptr;
      end
   end

   always_comb begin
      eof_set = beat_take && last_beat && !cur_cmd && cur_eof;
      qd_set  = (state == S_NEXT) && !enable;
      qd_clr  = (state == S_IDLE) && enable;
      err_clr = qd_clr;
      err_set = ((state == S_IDLE) && enable && (start_addr[4:0] != 5'd0))
             || ((state == S_NEXT) && enable && (d_next[4:0] != 5'd0))
             || ((state == S_CHECK) && first && !d_cmd[CB_CMD]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         fidx      <= '0;
         desc_addr <= '0;
         src_ptr   <= '0;
         hold      <= '0;
         first     <= 1'b0;
         cur_cmd   <= 1'b0;
         cur_eof   <= 1'b0;
         rem       <= '0;
         sub       <= '0;
         pix_fmt   <= 2'd0;
      end else begin
         case (state)
            S_IDLE: if (enable) begin
               if (start_addr[4:0] != 5'd0) state <= S_ERR;
               else begin
                  desc_addr <= start_addr;
                  fidx      <= '0;
                  first     <= 1'b1;
                  state     <= S_FETCH;
               end
            end
            S_FETCH: if (mem_ack) begin
               fidx <= fidx + 3'd1;
               if (fidx == 3'(DESC_WORDS - 1)) state <= S_CHECK;
            end
            S_CHECK: begin
               first   <= 1'b0;
               src_ptr <= d_src;
               cur_cmd <= d_cmd[CB_CMD];
               cur_eof <= d_cmd[CB_EOF];
               if (first && !d_cmd[CB_CMD]) state <= S_ERR;
               else if (d_cmd[CB_CMD]) begin
                  rem   <= d_cnt[CNT_W-1:0];
                  state <= (d_cnt[CNT_W-1:0] == '0) ? S_NEXT : S_RD;
               end else begin
                  case (d_cnt[30:27])
                     4'b0100: pix_fmt <= 2'd0;
                     4'b0101: pix_fmt <= 2'd1;
                     4'b1100: pix_fmt <= 2'd2;
                     default: pix_fmt <= 2'd3;
                  endcase
                  rem   <= d_cmd[CNT_W-1:0];
                  state <= (d_cmd[CB_FRM] && d_cmd[CNT_W-1:0] != '0) ? S_RD : S_NEXT;
               end
            end
            S_RD: if (mem_ack) begin
               hold    <= mem_rdata;
               src_ptr <= src_ptr + 32'd4;
               sub     <= '0;
               state   <= S_OUT;
            end
            S_OUT: if (out_ready) begin
               rem <= rem - CNT_W'(1);
               if (last_beat) state <= S_NEXT;
               else if (cur_cmd && sub != LAST_SUB) sub <= sub + 2'd1;
               else state <= S_RD;
            end
            S_NEXT: begin
               if (!enable) state <= S_IDLE;
               else if (d_next[4:0] != 5'd0) state <= S_ERR;
               else begin
                  desc_addr <= d_next;
                  fidx      <= '0;
                  state     <= S_FETCH;
               end
            end
            S_ERR: if (!enable) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   // R2: every descriptor fetch begins on a 32-byte boundary
   a_r2_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && state == S_FETCH && fidx == 3'd0) |-> (mem_addr[4:0] == 5'd0));

   // R2/R3: a halted engine emits nothing and is not busy
   a_r3_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> (!out_valid && !busy));

   // R10: a stalled beat is held unchanged
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_is_cmd)));

   // R11: the stopped flag never coexists with activity
   a_r11_qd_idle: assert property (@(posedge clk) disable iff (!rst_n)
      qd_flag |-> !busy);

   // R8: end of frame only follows an accepted beat
   a_r8_eof_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eof_flag) |-> $past(out_valid && out_ready));
endmodule

// File: tb/sim_dfd_engine.sv
`timescale 1ns/1ps
module sim_dfd_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [31:0] start_addr = '0;
   logic        eof_clr = 1'b0;
   logic        mem_req, mem_ack;
   logic [31:0] mem_addr, mem_rdata;
   logic        out_valid, out_is_cmd, busy, eof_flag, qd_flag, err_flag;
   logic        out_ready = 1'b1;
   logic [31:0] out_data;
   logic [1:0]  pix_fmt;

   int checks = 0;
   int errors = 0;
   logic [31:0] mem [64];

   always #2.5 clk = ~clk;

   assign mem_ack   = mem_req;
   assign mem_rdata = mem[mem_addr[7:2]];

   dfd_engine #(.CMD_BITS(8), .CNT_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start_addr(start_addr),
      .eof_clr(eof_clr), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_is_cmd(out_is_cmd),
      .busy(busy), .eof_flag(eof_flag), .qd_flag(qd_flag),
      .err_flag(err_flag), .pix_fmt(pix_fmt)
   );

   // {stall, is_cmd, data}: two laps of the ring at 0x00 -> 0x20 -> 0x00
   localparam logic [33:0] VEC [13] = '{
      {1'b0, 1'b1, 32'h0000_0011}, {1'b0, 1'b1, 32'h0000_0022},
      {1'b1, 1'b1, 32'h0000_0033}, {1'b0, 1'b1, 32'h0000_0044},
      {1'b0, 1'b1, 32'h0000_00AA}, {1'b0, 1'b0, 32'hF000_0001},
      {1'b1, 1'b0, 32'hF000_0002}, {1'b0, 1'b0, 32'hF000_0003},
      {1'b0, 1'b1, 32'h0000_0011}, {1'b0, 1'b1, 32'h0000_0022},
      {1'b0, 1'b1, 32'h0000_0033}, {1'b0, 1'b1, 32'h0000_0044},
      {1'b0, 1'b1, 32'h0000_00AA}
   };

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put_desc(input int base, input logic [31:0] nxt, input logic [31:0] src,
                           input logic [31:0] cmd, input logic [31:0] cnt);
      for (int k = 0; k < 8; k++) mem[base + k] = 32'd0;
      mem[base + 0] = nxt;
      mem[base + 1] = src;
      mem[base + 3] = cmd;
      mem[base + 6] = cnt;
   endtask

   task automatic do_reset();
      enable = 1'b0;
      out_ready = 1'b1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_beat();
      int guard = 0;
      @(negedge clk);
      while (!out_valid && guard < 200) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic get_beat(input logic [31:0] exp, input logic exp_cmd, input string req);
      wait_beat();
      check(out_valid, req, {31'd0, out_valid}, 32'd1);
      check(out_data == exp, req, out_data, exp);
      check(out_is_cmd == exp_cmd, req, {31'd0, out_is_cmd}, {31'd0, exp_cmd});
   endtask

   task automatic count_valid(input int n, output int seen);
      seen = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (out_valid) seen++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seen;
      for (int k = 0; k < 64; k++) mem[k] = 32'd0;
      put_desc(0,  32'h20, 32'h80, 32'h2000_0002, 32'd5);                // command, 5 beats
      put_desc(8,  32'h00, 32'hC0, 32'h4400_0003, 32'h2000_0000);         // frame, EOF, 16 bpp
      put_desc(16, 32'h20, 32'h00, 32'h2000_0000, 32'd0);                 // zero-count command
      put_desc(24, 32'hA0, 32'hC0, 32'h0400_0001, 32'h6000_0000);         // frame, no EOF, 15 bpp
      put_desc(40, 32'h60, 32'h00, 32'h2000_0000, 32'd0);                 // zero-count command
      mem[32] = 32'h4433_2211;
      mem[33] = 32'h0000_00AA;
      mem[48] = 32'hF000_0001;
      mem[49] = 32'hF000_0002;
      mem[50] = 32'hF000_0003;

      // R1 reset state
      do_reset();
      check(!busy && !out_valid && !mem_req, "R1", {29'd0, busy, out_valid, mem_req}, 32'd0);
      check(!eof_flag && !qd_flag && !err_flag, "R1",
            {29'd0, eof_flag, qd_flag, err_flag}, 32'd0);

      // R4 R6 R9 R10: vector walk over two laps
      start_addr = 32'h0;
      enable = 1'b1;
      for (int i = 0; i < 13; i++) begin
         logic [31:0] held;
         get_beat(VEC[i][31:0], VEC[i][32], i < 5 ? "R4" : (i < 8 ? "R6" : "R9"));
         if (VEC[i][33]) begin
            held = out_data;
            out_ready = 1'b0;
            repeat (3) @(negedge clk);
            check(out_valid && out_data == held, "R10", out_data, held);
            out_ready = 1'b1;
         end
      end
      check(busy, "R12", {31'd0, busy}, 32'd1);
      check(pix_fmt == 2'd0, "R7", {30'd0, pix_fmt}, 32'd0);
      check(eof_flag, "R8", {31'd0, eof_flag}, 32'd1);
      eof_clr = 1'b1;
      @(negedge clk);
      eof_clr = 1'b0;
      @(negedge clk);
      check(!eof_flag, "R8", {31'd0, eof_flag}, 32'd0);

      // R11: stop request mid-command still drains the descriptor
      do_reset();
      start_addr = 32'h0;
      enable = 1'b1;
      get_beat(32'h11, 1'b1, "R11");
      enable = 1'b0;
      get_beat(32'h22, 1'b1, "R11");
      get_beat(32'h33, 1'b1, "R11");
      get_beat(32'h44, 1'b1, "R11");
      get_beat(32'hAA, 1'b1, "R11");
      check(busy && !qd_flag, "R12", {30'd0, busy, qd_flag}, 32'd2);
      count_valid(10, seen);
      check(seen == 0, "R11", seen, 32'd0);
      check(qd_flag && !busy, "R11", {30'd0, qd_flag, busy}, 32'd2);

      // R5: restart on a zero-count command; qd clears, first beat is frame data
      start_addr = 32'h40;
      enable = 1'b1;
      repeat (2) @(negedge clk);
      check(!qd_flag, "R11", {31'd0, qd_flag}, 32'd0);
      get_beat(32'hF000_0001, 1'b0, "R5");

      // R7 R8: frame without EOF request, 15 bpp, looping through a zero command
      do_reset();
      start_addr = 32'hA0;
      enable = 1'b1;
      get_beat(32'hF000_0001, 1'b0, "R6");
      check(pix_fmt == 2'd2, "R7", {30'd0, pix_fmt}, 32'd2);
      get_beat(32'hF000_0001, 1'b0, "R9");
      repeat (30) @(negedge clk);
      check(!eof_flag, "R8", {31'd0, eof_flag}, 32'd0);

      // R3: first descriptor is a frame
      do_reset();
      start_addr = 32'h20;
      enable = 1'b1;
      count_valid(30, seen);
      check(seen == 0, "R3", seen, 32'd0);
      check(err_flag && !busy, "R3", {30'd0, err_flag, busy}, 32'd2);

      // R2: misaligned start address
      do_reset();
      start_addr = 32'h04;
      enable = 1'b1;
      count_valid(10, seen);
      check(seen == 0 && !mem_req, "R2", seen, 32'd0);
      check(err_flag, "R2", {31'd0, err_flag}, 32'd1);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule